// File: doc/BRIEF.md
# GPIO Pin Direction Control with Alias Registers

This block holds the direction state of a multi-group GPIO port. There is one bit per pin, and 1 marks an output. Each group of up to 32 pins has its own register bank. Software can change the direction state in four ways: write it whole, set selected bits, clear selected bits, or invert selected bits. The last three need no read-modify-write. All four addresses read back the same state.

A per-pin attribution mask marks pins as non-secure. A bus master flagged non-secure can only see and change the pins marked in that mask. The mask itself can only be written by secure accesses.

The bus is a plain synchronous register port. A write takes effect at the clock edge of the write cycle. Reads are combinational from the current state. The direction state of all groups is driven out as one flat vector, with group g occupying bits [g*PIN_W +: PIN_W].

Top module: `gpio_dir_port`

## Requirements
- R1: After reset every direction bit of every group is 0 and every attribution mask reads 0.
- R2: A write to group offset 0x08 sets each direction bit whose data bit is 1. Bits written 0 keep their value.
- R3: A write to group offset 0x04 clears each direction bit whose data bit is 1. Bits written 0 keep their value.
- R4: A write to group offset 0x0C inverts each direction bit whose data bit is 1. Bits written 0 keep their value.
- R5: A write to group offset 0x00 replaces the direction bits. Direction state changes only on a bus write cycle.
- R6: Reads at offsets 0x00, 0x04, 0x08 and 0x0C all return the same direction state. The read is combinational, so a write is visible in the cycle after its edge.
- R7: Group g's bank starts at byte address g*0x80 and drives pin_dir_o[g*PIN_W +: PIN_W]. A write to one group leaves every other group unchanged.
- R8: A non-secure write (bus_secure=0) changes only the direction bits whose attribution mask bit is 1. Other bits are silently kept.
- R9: A non-secure read of a direction offset returns 0 in every bit position whose attribution mask bit is 0.
- R10: The attribution mask sits at group offset 0x30. It is writable only by a secure access and readable by any access. A non-secure write to it has no effect.
- R11: Unmapped offsets, and groups at or above NUM_GROUPS, read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 = secure access, 0 = non-secure |
| bus_rdata | output | 32 | Combinational read data |
| pin_dir_o | output | NUM_GROUPS*PIN_W | Direction bits of all groups, 1 = output |

## Verification
The four write styles are tried on overlapping bit patterns. Each later pattern depends on the state left by the earlier ones, so an alias that acted as another alias, or that acted on zero bits, gives a different value. Reading each result through a different alias shows that all four offsets share one state.

Secure and non-secure writes are then applied with a partial attribution mask. This separates correct gating from no gating and from full blocking. Writes to a second group, to an unmapped offset and to a group out of range show that decoding keeps each write confined to its target.

// File: rtl/gpio_dir_pkg.sv
package gpio_dir_pkg;
    localparam int DATA_W     = 32;
    localparam int OFF_W      = 7;   // 0x80 bytes per group bank
    localparam logic [OFF_W-1:0] OFF_DIR  = 7'h00;
    localparam logic [OFF_W-1:0] OFF_CLR  = 7'h04;
    localparam logic [OFF_W-1:0] OFF_SET  = 7'h08;
    localparam logic [OFF_W-1:0] OFF_TGL  = 7'h0C;
    localparam logic [OFF_W-1:0] OFF_NSEC = 7'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_CLR,
        SEL_SET,
        SEL_TGL,
        SEL_NSEC
    } reg_sel_e;
endpackage

// File: rtl/gpio_dir_decode.sv
module gpio_dir_decode
    import gpio_dir_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_GROUPS = 2,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [GRP_W-1:0]  grp,
    output reg_sel_e          sel
);
    localparam int HI_W = ADDR_W - OFF_W;

    logic [HI_W-1:0]  grp_full;
    logic [OFF_W-1:0] off;
    logic             grp_ok;

    assign grp_full = addr[ADDR_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign grp_ok   = (int'(grp_full) < NUM_GROUPS);
    assign grp      = GRP_W'(grp_full);

    always_comb begin
        sel = SEL_NONE;
        if (grp_ok) begin
            unique case (off)
                OFF_DIR:  sel = SEL_DIR;
                OFF_CLR:  sel = SEL_CLR;
                OFF_SET:  sel = SEL_SET;
                OFF_TGL:  sel = SEL_TGL;
                OFF_NSEC: sel = SEL_NSEC;
                default:  sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_dir_bank.sv
module gpio_dir_bank
    import gpio_dir_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic             secure,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] nsec_q
);
    logic [PIN_W-1:0] acc_mask;
    logic [PIN_W-1:0] hit;
    logic [PIN_W-1:0] dir_d;

    assign acc_mask = secure ? {PIN_W{1'b1}} : nsec_q;
    assign hit      = wdata & acc_mask;

    always_comb begin
        dir_d = dir_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DIR: dir_d = (dir_q & ~acc_mask) | hit;
                SEL_CLR: dir_d = dir_q & ~hit;
                SEL_SET: dir_d = dir_q | hit;
                SEL_TGL: dir_d = dir_q ^ hit;
                default: dir_d = dir_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            nsec_q <= '0;
        end else begin
            dir_q <= dir_d;
            if (wr_en && secure && sel == SEL_NSEC)
                nsec_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_dir_port.sv
module gpio_dir_port
    import gpio_dir_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_GROUPS = 2,
    parameter int PIN_W      = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_secure,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [NUM_GROUPS*PIN_W-1:0] pin_dir_o
);
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    logic [GRP_W-1:0]            grp;
    reg_sel_e                    sel;
    logic [PIN_W-1:0]            dir_q  [NUM_GROUPS];
    logic [PIN_W-1:0]            nsec_q [NUM_GROUPS];
    logic [NUM_GROUPS*PIN_W-1:0] nsec_flat;

    gpio_dir_decode #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)) u_dec (
        .addr (bus_addr),
        .grp  (grp),
        .sel  (sel)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        gpio_dir_bank #(.PIN_W(PIN_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we && (sel != SEL_NONE) && (int'(grp) == g)),
            .sel    (sel),
            .secure (bus_secure),
            .wdata  (bus_wdata[PIN_W-1:0]),
            .dir_q  (dir_q[g]),
            .nsec_q (nsec_q[g])
        );
        assign pin_dir_o[g*PIN_W +: PIN_W] = dir_q[g];
        assign nsec_flat[g*PIN_W +: PIN_W] = nsec_q[g];
    end

    logic [PIN_W-1:0] rd_dir;
    logic [PIN_W-1:0] rd_nsec;

    always_comb begin
        rd_dir  = '0;
        rd_nsec = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (int'(grp) == g) begin
                rd_dir  = dir_q[g];
                rd_nsec = nsec_q[g];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DIR, SEL_CLR, SEL_SET, SEL_TGL:
                bus_rdata = DATA_W'(bus_secure ? rd_dir : (rd_dir & rd_nsec));
            SEL_NSEC:
                bus_rdata = DATA_W'(rd_nsec);
            default:
                bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_dir_port_chk.sv
module gpio_dir_port_chk
    import gpio_dir_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_GROUPS = 2,
    parameter int PIN_W      = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic                        bus_secure,
    input logic [NUM_GROUPS*PIN_W-1:0] pin_dir_o,
    input logic [NUM_GROUPS*PIN_W-1:0] nsec_flat
);
    logic [OFF_W-1:0] c_off;
    assign c_off = bus_addr[OFF_W-1:0];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_dir_o)); // R5

    AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && c_off == OFF_SET) |=> (($past(pin_dir_o) & ~pin_dir_o) == '0)); // R2

    AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && c_off == OFF_CLR) |=> ((~$past(pin_dir_o) & pin_dir_o) == '0)); // R3

    AST_NS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_secure) |=>
            (((pin_dir_o ^ $past(pin_dir_o)) & ~$past(nsec_flat)) == '0)); // R8

    AST_NSEC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_secure) |=> $stable(nsec_flat)); // R10
endmodule

bind gpio_dir_port gpio_dir_port_chk #(
    .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS), .PIN_W(PIN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_secure (bus_secure),
    .pin_dir_o  (pin_dir_o),
    .nsec_flat  (nsec_flat)
);

// File: tb/gpio_dir_port_test.sv
module gpio_dir_port_test;
    localparam int ADDR_W = 12;
    localparam int NG     = 2;
    localparam int PW     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_secure = 1'b1;
    logic [31:0]       bus_rdata;
    logic [NG*PW-1:0]  pin_dir_o;

    int n_run = 0;
    int n_fail = 0;

    gpio_dir_port #(.ADDR_W(ADDR_W), .NUM_GROUPS(NG), .PIN_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(bus_rdata), .pin_dir_o(pin_dir_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct packed {
        logic        we;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic        wsec;
        logic [11:0] raddr;
        logic        rsec;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h008, 32'h0000_00F0, 1'b1, 12'h000, 1'b1, 32'h0000_00F0, 4'd2},  // R2 set
        '{1'b1, 12'h008, 32'h0000_0000, 1'b1, 12'h000, 1'b1, 32'h0000_00F0, 4'd2},  // R2 zeros
        '{1'b1, 12'h004, 32'h0000_0030, 1'b1, 12'h008, 1'b1, 32'h0000_00C0, 4'd3},  // R3 clear
        '{1'b1, 12'h004, 32'h0000_0000, 1'b1, 12'h00C, 1'b1, 32'h0000_00C0, 4'd3},  // R3 zeros
        '{1'b1, 12'h00C, 32'h0000_0F80, 1'b1, 12'h00C, 1'b1, 32'h0000_0F40, 4'd4},  // R4 toggle
        '{1'b1, 12'h00C, 32'h0000_0000, 1'b1, 12'h004, 1'b1, 32'h0000_0F40, 4'd4},  // R4 zeros
        '{1'b1, 12'h000, 32'hA5A5_0000, 1'b1, 12'h004, 1'b1, 32'hA5A5_0000, 4'd5},  // R5 direct
        '{1'b0, 12'h000, 32'h0000_0000, 1'b1, 12'h008, 1'b1, 32'hA5A5_0000, 4'd6},  // R6 alias read
        '{1'b1, 12'h088, 32'h0000_0001, 1'b1, 12'h080, 1'b1, 32'h0000_0001, 4'd7},  // R7 group 1
        '{1'b0, 12'h000, 32'h0000_0000, 1'b1, 12'h000, 1'b1, 32'hA5A5_0000, 4'd7},  // R7 group 0 kept
        '{1'b1, 12'h030, 32'h0000_FFFF, 1'b1, 12'h030, 1'b1, 32'h0000_FFFF, 4'd10}, // R10 secure write
        '{1'b1, 12'h030, 32'hFFFF_FFFF, 1'b0, 12'h030, 1'b0, 32'h0000_FFFF, 4'd10}, // R10 ns write dropped
        '{1'b1, 12'h008, 32'hFFFF_FFFF, 1'b0, 12'h000, 1'b1, 32'hA5A5_FFFF, 4'd8},  // R8 ns set
        '{1'b1, 12'h004, 32'hFFFF_FFFF, 1'b0, 12'h000, 1'b1, 32'hA5A5_0000, 4'd8},  // R8 ns clear
        '{1'b1, 12'h000, 32'h1234_5678, 1'b0, 12'h000, 1'b1, 32'hA5A5_5678, 4'd8},  // R8 ns direct
        '{1'b0, 12'h000, 32'h0000_0000, 1'b0, 12'h00C, 1'b0, 32'h0000_5678, 4'd9},  // R9 ns read g0
        '{1'b0, 12'h000, 32'h0000_0000, 1'b0, 12'h080, 1'b0, 32'h0000_0000, 4'd9},  // R9 ns read g1
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 1'b1, 12'h010, 1'b1, 32'h0000_0000, 4'd11}, // R11 unmapped
        '{1'b1, 12'h108, 32'hFFFF_FFFF, 1'b1, 12'h100, 1'b1, 32'h0000_0000, 4'd11}  // R11 group out of range
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, read combinationally before the next posedge
    task automatic bus_read(input logic [11:0] a, input logic sec, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; bus_secure = sec;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        bus_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 pins after reset", 64'(pin_dir_o), 64'h0);
        bus_read(12'h030, 1'b1, rd);
        check("R1 mask g0 after reset", 64'(rd), 64'h0);
        bus_read(12'h0B0, 1'b1, rd);
        check("R1 mask g1 after reset", 64'(rd), 64'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_we = VECS[i].we; bus_addr = VECS[i].waddr;
            bus_wdata = VECS[i].wdata; bus_secure = VECS[i].wsec;
            bus_read(VECS[i].raddr, VECS[i].rsec, rd);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(rd), 64'(VECS[i].exp));
        end

        // R11: earlier unmapped / out-of-range writes left all state alone
        bus_read(12'h000, 1'b1, rd);
        check("R11 g0 untouched", 64'(rd), 64'hA5A5_5678);
        #1 check("R7 pin_dir_o layout", 64'(pin_dir_o), {32'h0000_0001, 32'hA5A5_5678});

        // R6: write-then-read in consecutive cycles via toggle alias
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h08C; bus_wdata = 32'h0000_0003; bus_secure = 1'b1;
        bus_read(12'h084, 1'b1, rd);
        check("R6 next-cycle visibility", 64'(rd), 64'h0000_0002);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 pins after second reset", 64'(pin_dir_o), 64'h0);
        bus_read(12'h030, 1'b1, rd);
        check("R1 mask after second reset", 64'(rd), 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule